// File: doc/BRIEF.md
# Dual Wiper Register Controller

This block holds the digital state of two 64-position potentiometers. Each channel keeps a 6-bit volatile wiper register, whose value picks exactly one of 64 tap switches through a one-hot select vector, and four stored position registers. The stored registers are ordinary flops that keep their contents across `rst_n`, standing in for nonvolatile cells. A write to one of them starts a busy window that stands in for the programming time.

The host reaches the block through a byte stream that has already been recovered from a 2-wire serial bus. `rx_start` marks a start condition and `rx_valid` qualifies each received byte. The first byte is the device address: the upper nibble is a fixed device-type code (parameter, default 4'b0101), and the lower nibble must equal the `addr_pins` strap. The second byte is a command: bits [7:4] are the opcode, bits [3:2] the stored-register index and bits [1:0] the pot select. Write commands take a third byte whose low six bits are the new value. The block answers with a one-cycle `ack` pulse for each byte it accepts, and with a `tx_valid`/`tx_data` pulse for reads.

The sequencer is one state machine. S_RECALL is the reset state; it copies stored register 0 of each pot into that pot's wiper and then goes to S_IDLE. S_IDLE waits for `rx_start` and then goes to S_ADDR. S_ADDR takes the address byte: on a match while not busy it goes to S_INSTR, and otherwise it drops back to S_IDLE. S_INSTR decodes the command. Reads and reload commands finish there and return to S_IDLE. The two write commands move on to S_DATA. A rejected command returns to S_IDLE. S_DATA takes the value byte, performs the write and returns to S_IDLE. From every state except S_RECALL, `rx_start` goes to S_ADDR.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: The two pots are independent: a command aimed at one pot never changes the other pot's wiper or tap select.
- R2: Each tap select output is 64 bits with exactly one bit set; bit w is set when the wiper holds w. The output follows a wiper change one clock later.
- R3: After `rst_n` is released, each pot's wiper takes the value of that pot's stored register 0, and the stored registers keep their contents through reset. During reset `ack`, `tx_valid` and `busy` are 0.
- R4: Opcode 4'hA followed by a value byte loads bits [5:0] of the value byte into the selected wiper; bits [7:6] are ignored.
- R5: Opcode 4'h9 returns the selected wiper as `tx_data` = {2'b00, wiper}, with `tx_valid` high for one cycle, one clock after the command byte is sampled.
- R6: Opcode 4'hC followed by a value byte writes bits [5:0] into stored register [3:2] of the selected pot. Opcode 4'hB returns that register on `tx_data` with the timing of R5.
- R7: Opcode 4'hD copies stored register [3:2] of the selected pot into its wiper as the command byte is sampled.
- R8: An address byte is acknowledged only when bits [7:4] equal the type code and bits [3:0] equal `addr_pins`. Otherwise it is not acknowledged, and the rest of the frame is ignored.
- R9: A command with pot select 2'b10 or 2'b11, or with an opcode other than 9, A, B, C or D, is not acknowledged and changes nothing; the rest of the frame is ignored.
- R10: A stored-register write raises `busy` for exactly BUSY_CYCLES clocks (default 16), starting one clock after the value byte. An address byte received while `busy` is high is not acknowledged.
- R11: `ack` pulses for one cycle, one clock after each accepted byte is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_pins | input | 4 | Strapped low nibble of the device address |
| rx_start | input | 1 | Start condition seen on the bus |
| rx_valid | input | 1 | rx_data holds a received byte |
| rx_data | input | 8 | Received byte |
| ack | output | 1 | Byte accepted (one-cycle pulse) |
| tx_valid | output | 1 | Read data is present on tx_data |
| tx_data | output | 8 | Read data, zero-extended |
| busy | output | 1 | Stored-register write in progress |
| tap0_sel | output | 64 | One-hot tap select of pot 0 |
| tap1_sel | output | 64 | One-hot tap select of pot 1 |

## Verification
`ack`, `tx_valid` and `tx_data` are registered and are due one clock after the byte that causes them, so the bench drives each byte at a falling edge and reads these outputs at the next falling edge. A wiper changes at the edge that samples its value or reload command, and the tap select follows one edge later, so tap checks wait exactly one further falling edge. `busy` rises one clock after the value byte of a stored write; the bench counts the falling edges at which it is high and expects BUSY_CYCLES. The recall result is checked a few clocks after reset release, after S_RECALL and the tap register have both had their edge.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
    localparam int NPOT  = 2;
    localparam int TAP_W = 6;
    localparam int NDR   = 4;
    localparam int IDX_W = $clog2(NDR);
    localparam int POT_W = $clog2(NPOT);

    localparam logic [3:0] OP_RD_WIPER = 4'h9;
    localparam logic [3:0] OP_WR_WIPER = 4'hA;
    localparam logic [3:0] OP_RD_STORE = 4'hB;
    localparam logic [3:0] OP_WR_STORE = 4'hC;
    localparam logic [3:0] OP_LOAD     = 4'hD;

    typedef enum logic [2:0] {
        S_RECALL,
        S_IDLE,
        S_ADDR,
        S_INSTR,
        S_DATA
    } fsm_state_e;
endpackage

// File: rtl/dwc_busy_timer.sv
module dwc_busy_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R10
    busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dwc_channel.sv
module dwc_channel #(
    parameter int TAP_W = 6,
    parameter int NDR   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    recall_en,
    input  logic                    wr_wiper_en,
    input  logic                    wr_store_en,
    input  logic                    load_en,
    input  logic [$clog2(NDR)-1:0]  idx,
    input  logic [TAP_W-1:0]        wdata,
    output logic [TAP_W-1:0]        wiper,
    output logic [TAP_W-1:0]        store_rd,
    output logic [(1<<TAP_W)-1:0]   tap_sel
);
    localparam int NTAP = 1 << TAP_W;

    logic [TAP_W-1:0] store_q [NDR];
    logic [TAP_W-1:0] wiper_q;
    logic [NTAP-1:0]  tap_d;
    logic [NTAP-1:0]  tap_q;

    // stored registers keep their contents across reset (nonvolatile model)
    for (genvar r = 0; r < NDR; r++) begin : g_store
        always_ff @(posedge clk) begin
            if (wr_store_en && (idx == r[$clog2(NDR)-1:0])) begin
                store_q[r] <= wdata;
            end
        end
    end

    assign store_rd = store_q[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper_q <= '0;
        end else if (recall_en) begin
            wiper_q <= store_q[0];
        end else if (load_en) begin
            wiper_q <= store_rd;
        end else if (wr_wiper_en) begin
            wiper_q <= wdata;
        end
    end

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign tap_d[t] = (wiper_q == TAP_W'(t));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= NTAP'(1);
        end else begin
            tap_q <= tap_d;
        end
    end

    assign wiper   = wiper_q;
    assign tap_sel = tap_q;

    // R2
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_q) == 1);

    // R2
    tap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tap_q == (NTAP'(1) << $past(wiper_q))));

    // R3
    recall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_en |=> (wiper_q == $past(store_q[0])));

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !recall_en) |=> (wiper_q == $past(store_rd)));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall_en && !load_en && !wr_wiper_en) |=> $stable(wiper_q));
endmodule

// File: rtl/dwc_cmd_fsm.sv
module dwc_cmd_fsm
    import dwc_pkg::*;
#(
    parameter int         TAP_W     = 6,
    parameter logic [3:0] TYPE_CODE = 4'b0101
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [3:0]                  addr_pins,
    input  logic                        rx_start,
    input  logic                        rx_valid,
    input  logic [7:0]                  rx_data,
    input  logic                        busy,
    input  logic [NPOT-1:0][TAP_W-1:0]  rd_wiper,
    input  logic [NPOT-1:0][TAP_W-1:0]  rd_store,
    output logic                        recall_en,
    output logic [NPOT-1:0]             wr_wiper_en,
    output logic [NPOT-1:0]             wr_store_en,
    output logic [NPOT-1:0]             load_en,
    output logic [IDX_W-1:0]            sel_idx,
    output logic [TAP_W-1:0]            wdata,
    output logic                        ack,
    output logic                        tx_valid,
    output logic [7:0]                  tx_data
);
    fsm_state_e       state_q, state_d;
    logic [3:0]       op_q;
    logic [IDX_W-1:0] idx_q;
    logic [POT_W-1:0] pot_q;
    logic             ctx_load;
    logic             ack_d, tx_valid_d;
    logic [7:0]       tx_data_d;
    logic             ack_q, tx_valid_q;
    logic [7:0]       tx_data_q;

    logic [3:0]       in_op;
    logic [IDX_W-1:0] in_idx;
    logic [POT_W-1:0] in_pot;
    logic             in_pot_ok;
    logic             addr_ok;

    assign in_op     = rx_data[7:4];
    assign in_idx    = rx_data[3:2];
    assign in_pot    = rx_data[POT_W-1:0];
    assign in_pot_ok = (rx_data[1:0] < 2'(NPOT));
    assign addr_ok   = (rx_data[7:4] == TYPE_CODE) && (rx_data[3:0] == addr_pins);

    assign sel_idx = (state_q == S_INSTR) ? in_idx : idx_q;
    assign wdata   = rx_data[TAP_W-1:0];

    // next state and strobes
    always_comb begin
        state_d     = state_q;
        recall_en   = 1'b0;
        wr_wiper_en = '0;
        wr_store_en = '0;
        load_en     = '0;
        ctx_load    = 1'b0;
        ack_d       = 1'b0;
        tx_valid_d  = 1'b0;
        tx_data_d   = '0;
        unique case (state_q)
            S_RECALL: begin
                recall_en = 1'b1;
                state_d   = S_IDLE;
            end
            S_IDLE: begin
                if (rx_start) state_d = S_ADDR;
            end
            S_ADDR: begin
                if (rx_start) begin
                    state_d = S_ADDR;
                end else if (rx_valid) begin
                    if (addr_ok && !busy) begin
                        ack_d   = 1'b1;
                        state_d = S_INSTR;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
            end
            S_INSTR: begin
                if (rx_start) begin
                    state_d = S_ADDR;
                end else if (rx_valid) begin
                    state_d = S_IDLE;
                    if (in_pot_ok) begin
                        case (in_op)
                            OP_RD_WIPER: begin
                                ack_d                = 1'b1;
                                tx_valid_d           = 1'b1;
                                tx_data_d[TAP_W-1:0] = rd_wiper[in_pot];
                            end
                            OP_RD_STORE: begin
                                ack_d                = 1'b1;
                                tx_valid_d           = 1'b1;
                                tx_data_d[TAP_W-1:0] = rd_store[in_pot];
                            end
                            OP_WR_WIPER, OP_WR_STORE: begin
                                ack_d    = 1'b1;
                                ctx_load = 1'b1;
                                state_d  = S_DATA;
                            end
                            OP_LOAD: begin
                                ack_d           = 1'b1;
                                load_en[in_pot] = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            S_DATA: begin
                if (rx_start) begin
                    state_d = S_ADDR;
                end else if (rx_valid) begin
                    ack_d   = 1'b1;
                    state_d = S_IDLE;
                    if (op_q == OP_WR_WIPER) begin
                        wr_wiper_en[pot_q] = 1'b1;
                    end else begin
                        wr_store_en[pot_q] = 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_RECALL;
        end else begin
            state_q <= state_d;
        end
    end

    // command context and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= '0;
            idx_q      <= '0;
            pot_q      <= '0;
            ack_q      <= 1'b0;
            tx_valid_q <= 1'b0;
            tx_data_q  <= '0;
        end else begin
            if (ctx_load) begin
                op_q  <= in_op;
                idx_q <= in_idx;
                pot_q <= in_pot;
            end
            ack_q      <= ack_d;
            tx_valid_q <= tx_valid_d;
            tx_data_q  <= tx_data_d;
        end
    end

    assign ack      = ack_q;
    assign tx_valid = tx_valid_q;
    assign tx_data  = tx_data_q;

    // R5
    tx_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ack);

    // R8
    addr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR && rx_valid && !rx_start && !addr_ok) |=> !ack);

    // R10
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR && rx_valid && !rx_start && busy) |=> !ack);

    // R9
    bad_pot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_INSTR && rx_valid && !rx_start && !in_pot_ok) |=> (!ack && state_q == S_IDLE));

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(rx_valid));
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
    import dwc_pkg::*;
#(
    parameter logic [3:0] TYPE_CODE   = 4'b0101,
    parameter int         BUSY_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  addr_pins,
    input  logic        rx_start,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        ack,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        busy,
    output logic [63:0] tap0_sel,
    output logic [63:0] tap1_sel
);
    localparam int NTAP = 1 << TAP_W;

    logic                        recall_en;
    logic [NPOT-1:0]             wr_wiper_en, wr_store_en, load_en;
    logic [IDX_W-1:0]            sel_idx;
    logic [TAP_W-1:0]            wdata;
    logic [NPOT-1:0][TAP_W-1:0]  rd_wiper, rd_store;
    logic [NPOT-1:0][NTAP-1:0]   taps;

    dwc_cmd_fsm #(.TAP_W(TAP_W), .TYPE_CODE(TYPE_CODE)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_pins   (addr_pins),
        .rx_start    (rx_start),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .busy        (busy),
        .rd_wiper    (rd_wiper),
        .rd_store    (rd_store),
        .recall_en   (recall_en),
        .wr_wiper_en (wr_wiper_en),
        .wr_store_en (wr_store_en),
        .load_en     (load_en),
        .sel_idx     (sel_idx),
        .wdata       (wdata),
        .ack         (ack),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data)
    );

    dwc_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (|wr_store_en),
        .busy  (busy)
    );

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        dwc_channel #(.TAP_W(TAP_W), .NDR(NDR)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .recall_en   (recall_en),
            .wr_wiper_en (wr_wiper_en[p]),
            .wr_store_en (wr_store_en[p]),
            .load_en     (load_en[p]),
            .idx         (sel_idx),
            .wdata       (wdata),
            .wiper       (rd_wiper[p]),
            .store_rd    (rd_store[p]),
            .tap_sel     (taps[p])
        );
    end

    assign tap0_sel = taps[0];
    assign tap1_sel = taps[1];

    // R3
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ack && !tx_valid && !busy));
endmodule

// File: tb/dual_wiper_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_wiper_ctrl_tb_top;
    localparam logic [3:0] TYPE  = 4'b0101;
    localparam logic [3:0] PINS  = 4'b1010;
    localparam logic [7:0] ADDR  = {TYPE, PINS};
    localparam int         BUSYN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr_pins = PINS;
    logic        rx_start = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        ack, tx_valid, busy;
    logic [7:0]  tx_data;
    logic [63:0] tap0_sel, tap1_sel;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic       got_ack, got_txv;
    logic [7:0] got_tx;
    logic [5:0] store_exp [2][4];

    always #2 clk = ~clk;

    dual_wiper_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
        .ack(ack), .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy),
        .tap0_sel(tap0_sel), .tap1_sel(tap1_sel)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic frame_start();
        @(negedge clk) rx_start = 1'b1;
        @(negedge clk) rx_start = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        got_ack  = ack;
        got_txv  = tx_valid;
        got_tx   = tx_data;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    function automatic logic [63:0] onehot(input int v);
        return 64'(1) << v;
    endfunction

    // full write-wiper frame (R4), with garbage in bits [7:6]
    task automatic write_wiper(input int p, input int v);
        frame_start();
        send(ADDR);
        check(got_ack == 1'b1, "R8 addr ack", 64'(got_ack), 64'd1);
        send({4'hA, 2'b00, 2'(p)});
        check(got_ack == 1'b1, "R11 cmd ack", 64'(got_ack), 64'd1);
        send({2'b11, 6'(v)});
        check(got_ack == 1'b1, "R4 data ack", 64'(got_ack), 64'd1);
        @(negedge clk);
    endtask

    task automatic read_cmd(input logic [3:0] op, input int p, input int i);
        frame_start();
        send(ADDR);
        send({op, 2'(i), 2'(p)});
    endtask

    initial begin
        int prev1;
        // reset state
        repeat (4) @(negedge clk);
        check(ack == 1'b0 && tx_valid == 1'b0, "R3 reset outputs quiet", 64'({ack, tx_valid}), 64'd0);
        check(busy == 1'b0, "R3 reset busy low", 64'(busy), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check($countones(tap0_sel) == 1, "R2 tap0 onehot", tap0_sel, 64'd1);
        check($countones(tap1_sel) == 1, "R2 tap1 onehot", tap1_sel, 64'd1);

        // sweep both wipers over every position
        prev1 = -1;
        for (int v = 0; v < 64; v++) begin
            logic [63:0] t1_before;
            t1_before = tap1_sel;
            write_wiper(0, v);
            check(tap0_sel == onehot(v), "R2 R4 tap0 position", tap0_sel, onehot(v));
            check(tap1_sel == t1_before, "R1 pot1 untouched", tap1_sel, t1_before);
            write_wiper(1, 63 - v);
            check(tap1_sel == onehot(63 - v), "R2 R4 tap1 position", tap1_sel, onehot(63 - v));
            check(tap0_sel == onehot(v), "R1 pot0 untouched", tap0_sel, onehot(v));
            read_cmd(4'h9, 0, 0);
            check(got_txv && got_ack, "R5 read valid", 64'({got_txv, got_ack}), 64'd3);
            check(got_tx == 8'(v), "R5 read pot0", 64'(got_tx), 64'(v));
            read_cmd(4'h9, 1, 3);
            check(got_tx == 8'(63 - v), "R5 read pot1", 64'(got_tx), 64'(63 - v));
            prev1 = 63 - v;
        end

        // stored registers: write all eight
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 4; i++) begin
                logic [5:0] val;
                val = 6'(((p * 4 + i) * 7 + 3) % 64);
                store_exp[p][i] = val;
                wait_idle();
                frame_start();
                send(ADDR);
                send({4'hC, 2'(i), 2'(p)});
                check(got_ack == 1'b1, "R6 store cmd ack", 64'(got_ack), 64'd1);
                send({2'b10, val});
                check(got_ack == 1'b1, "R6 store data ack", 64'(got_ack), 64'd1);
                if (p == 0 && i == 0) begin
                    int cnt;
                    cnt = 0;
                    while (busy && cnt < 1000) begin
                        cnt++;
                        @(negedge clk);
                    end
                    check(cnt == BUSYN, "R10 busy length", 64'(cnt), 64'(BUSYN));
                end else if (p == 0 && i == 1) begin
                    check(busy == 1'b1, "R10 busy raised", 64'(busy), 64'd1);
                    frame_start();
                    send(ADDR);
                    check(got_ack == 1'b0, "R10 addr refused while busy", 64'(got_ack), 64'd0);
                end
            end
        end
        wait_idle();
        check(tap1_sel == onehot(prev1), "R1 store write leaves wiper", tap1_sel, onehot(prev1));

        // read back and reload each stored register
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 4; i++) begin
                read_cmd(4'hB, p, i);
                check(got_txv == 1'b1, "R6 store read valid", 64'(got_txv), 64'd1);
                check(got_tx == {2'b00, store_exp[p][i]}, "R6 store read value", 64'(got_tx), 64'(store_exp[p][i]));
                read_cmd(4'hD, p, i);
                check(got_ack == 1'b1 && got_txv == 1'b0, "R7 reload ack", 64'({got_ack, got_txv}), 64'd2);
                @(negedge clk);
                if (p == 0)
                    check(tap0_sel == onehot(store_exp[0][i]), "R7 reload pot0", tap0_sel, onehot(store_exp[0][i]));
                else
                    check(tap1_sel == onehot(store_exp[1][i]), "R7 reload pot1", tap1_sel, onehot(store_exp[1][i]));
            end
        end
        // now tap0 = store[0][3], tap1 = store[1][3]

        // address mismatches (R8)
        frame_start();
        send(8'h9A);
        check(got_ack == 1'b0, "R8 wrong type code", 64'(got_ack), 64'd0);
        send({4'hA, 2'b00, 2'b00});
        check(got_ack == 1'b0, "R8 frame ignored", 64'(got_ack), 64'd0);
        send(8'h05);
        @(negedge clk);
        check(tap0_sel == onehot(store_exp[0][3]), "R8 wiper kept", tap0_sel, onehot(store_exp[0][3]));
        frame_start();
        send({TYPE, 4'b1011});
        check(got_ack == 1'b0, "R8 wrong pin bits", 64'(got_ack), 64'd0);

        // bad pot select and bad opcode (R9)
        frame_start();
        send(ADDR);
        send({4'hA, 2'b00, 2'b10});
        check(got_ack == 1'b0, "R9 pot 2 refused", 64'(got_ack), 64'd0);
        send(8'h07);
        check(got_ack == 1'b0, "R9 data ignored", 64'(got_ack), 64'd0);
        @(negedge clk);
        check(tap0_sel == onehot(store_exp[0][3]) && tap1_sel == onehot(store_exp[1][3]),
              "R9 taps kept", tap0_sel, onehot(store_exp[0][3]));
        frame_start();
        send(ADDR);
        send({4'h3, 2'b00, 2'b01});
        check(got_ack == 1'b0 && got_txv == 1'b0, "R9 unknown opcode", 64'({got_ack, got_txv}), 64'd0);
        read_cmd(4'hD, 3, 0);
        check(got_ack == 1'b0, "R9 pot 3 reload refused", 64'(got_ack), 64'd0);
        @(negedge clk);
        check(tap1_sel == onehot(store_exp[1][3]), "R9 pot1 kept", tap1_sel, onehot(store_exp[1][3]));

        // recall on reset (R3)
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(tap0_sel == onehot(store_exp[0][0]), "R3 recall pot0", tap0_sel, onehot(store_exp[0][0]));
        check(tap1_sel == onehot(store_exp[1][0]), "R3 recall pot1", tap1_sel, onehot(store_exp[1][0]));
        read_cmd(4'hB, 1, 2);
        check(got_tx == {2'b00, store_exp[1][2]}, "R3 stored kept through reset", 64'(got_tx), 64'(store_exp[1][2]));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R11: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule